// File: doc/BRIEF.md
# Dual-Port Mailbox Semaphore Controller

This block decides who may touch each of eight mailboxes in a data store that a host processor and a DSP share. Each mailbox has a one-bit semaphore and a direction bit. The direction bit names one side as the sender and the other side as the recipient. The semaphore then says which of the two currently owns the mailbox's words. Only the owner may read or write those words. Only the owner may flip the semaphore. A flip raises an interrupt flag toward the other side when that side's enable for the mailbox is set.

Both sides reach the block through identical single-cycle register buses. Read data is registered, and each port has a one-cycle access-violation pulse. A configuration word can be reached only from the host. It holds the direction bits, the two banks of interrupt enables, a two-bit partition mode and a self-clearing soft-reset bit. The partition mode splits the 32-word store into 8, 4, 2 or 1 mailboxes.

Top module: `mbox_sema_ctrl`

## Requirements
- R1: Address bit 5 set to 0 selects data word `addr[4:0]`. Address bit 5 set to 1 selects a register: index 0 to 7 is the semaphore word of that mailbox and index 8 is the configuration word. Read data appears on `*_rdata` the cycle after the request. A write cycle, or an access that returns nothing, produces 0 there.
- R2: Mailbox m is owned by the host when direction bit m XOR semaphore m is 1, and by the DSP otherwise. Direction 1 makes the host the sender, and a semaphore of 0 gives the mailbox to the sender.
- R3: A data access to a mailbox the requesting side does not own returns 0 and discards its write data. It also pulses that port's `*_viol` high for one cycle, together with the read data slot.
- R4: Only the current owner may write a semaphore, and the owner's `wdata[0]` becomes its new value. A semaphore write from the non-owner has no effect.
- R5: A semaphore change made by the host sets the DSP flag of that mailbox if the DSP enable bit is 1. A change made by the DSP sets the host flag if the host enable bit is 1. Rewriting the same value sets nothing.
- R6: A side's read of a semaphore word clears that side's own flag for the mailbox. If a set happens in the same cycle, the set wins. `h_irq` is the OR of all host flags and `d_irq` is the OR of all DSP flags.
- R7: A semaphore word reads as bit 0 = semaphore, bit 1 = host flag, bit 2 = DSP flag, with all higher bits 0. It reads the same from both ports. Writes to bits 1 and 2 are ignored.
- R8: The configuration word has direction bits in [7:0], host enables in [15:8], DSP enables in [23:16], partition mode in [30:29] and soft reset in [31]. Only the host can reach it. A DSP read of it returns 0 and a DSP write is ignored.
- R9: Partition mode p gives 8>>p mailboxes of 4<<p words. Word w belongs to mailbox w>>(2+p). Semaphore words of mailboxes beyond the active count read 0, and writes to them are ignored.
- R10: Writing 1 to configuration bit 31 clears every semaphore, flag and data word at the next clock edge. Bit 31 reads 1 for that one cycle only, and the other configuration fields are kept.
- R11: After hardware reset, all configuration fields, semaphores, flags, data words and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 6 | Host address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the request |
| h_viol | output | 1 | Host access-violation pulse |
| h_irq | output | 1 | Interrupt toward the host |
| d_en | input | 1 | DSP access request |
| d_we | input | 1 | DSP write (1) or read (0) |
| d_addr | input | 6 | DSP address |
| d_wdata | input | 32 | DSP write data |
| d_rdata | output | 32 | DSP read data, one cycle after the request |
| d_viol | output | 1 | DSP access-violation pulse |
| d_irq | output | 1 | Interrupt toward the DSP |

## Verification
The bench drives a full ownership round trip on one mailbox: sender set, recipient read, recipient release. A design that ties ownership to the semaphore value alone, without the direction bit, would give the DSP the first mailbox too early. The bench also sets a semaphore whose target enable is clear, and checks that no interrupt comes out. It tries a semaphore write while the mailbox is outside the active partition, then returns to the wider mode to show the write left nothing behind. It reads the configuration word in the cycle right after a soft reset, where a reset bit that never clears, or that is never visible, shows up as a wrong value.

// File: rtl/mbox_sema_ctrl.sv
module mbox_sema_ctrl #(
  parameter int NMB       = 8,
  parameter int MIN_WORDS = 4,
  parameter int DW        = 32,
  localparam int LOG_NMB   = $clog2(NMB),
  localparam int LOG_MIN   = $clog2(MIN_WORDS),
  localparam int LOG_WORDS = LOG_NMB + LOG_MIN,
  localparam int WORDS     = NMB * MIN_WORDS,
  localparam int REG_W     = LOG_NMB + 1,
  localparam int AW        = LOG_WORDS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_en,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_viol,
  output logic          h_irq,
  input  logic          d_en,
  input  logic          d_we,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  output logic [DW-1:0] d_rdata,
  output logic          d_viol,
  output logic          d_irq
);

  logic [NMB-1:0] dir_q, hie_q, die_q, sem_q, hflg_q, dflg_q;
  logic [NMB-1:0] sem_d, hflg_d, dflg_d;
  logic [1:0]     mode_q;
  logic           srst_q;
  logic [DW-1:0]  mem_q [WORDS];
  logic [DW-1:0]  cfg_word;

  logic [NMB-1:0] host_own;
  assign host_own = dir_q ^ sem_q;

  // host decode
  logic                 h_isreg, h_is_sem, h_is_cfg, h_act, h_own_mb, h_own_sem;
  logic [LOG_WORDS-1:0] h_word, h_sh;
  logic [REG_W-1:0]     h_rsel;
  logic [LOG_NMB-1:0]   h_mb, h_sidx;
  assign h_isreg   = h_addr[AW-1];
  assign h_word    = h_addr[LOG_WORDS-1:0];
  assign h_rsel    = h_addr[REG_W-1:0];
  assign h_sidx    = h_rsel[LOG_NMB-1:0];
  assign h_sh      = h_word >> (LOG_MIN + int'(mode_q));
  assign h_mb      = h_sh[LOG_NMB-1:0];
  assign h_is_sem  = h_isreg && (int'(h_rsel) < NMB);
  assign h_is_cfg  = h_isreg && (h_rsel == REG_W'(NMB));
  assign h_act     = int'(h_sidx) < (NMB >> mode_q);
  assign h_own_mb  = host_own[h_mb];
  assign h_own_sem = host_own[h_sidx];

  // dsp decode
  logic                 d_isreg, d_is_sem, d_act, d_own_mb, d_own_sem;
  logic [LOG_WORDS-1:0] d_word, d_sh;
  logic [REG_W-1:0]     d_rsel;
  logic [LOG_NMB-1:0]   d_mb, d_sidx;
  assign d_isreg   = d_addr[AW-1];
  assign d_word    = d_addr[LOG_WORDS-1:0];
  assign d_rsel    = d_addr[REG_W-1:0];
  assign d_sidx    = d_rsel[LOG_NMB-1:0];
  assign d_sh      = d_word >> (LOG_MIN + int'(mode_q));
  assign d_mb      = d_sh[LOG_NMB-1:0];
  assign d_is_sem  = d_isreg && (int'(d_rsel) < NMB);
  assign d_act     = int'(d_sidx) < (NMB >> mode_q);
  assign d_own_mb  = !host_own[d_mb];
  assign d_own_sem = !host_own[d_sidx];

  logic h_dat_ok, h_dat_blk, d_dat_ok, d_dat_blk;
  assign h_dat_ok  = h_en && !h_isreg && h_own_mb;
  assign h_dat_blk = h_en && !h_isreg && !h_own_mb;
  assign d_dat_ok  = d_en && !d_isreg && d_own_mb;
  assign d_dat_blk = d_en && !d_isreg && !d_own_mb;

  logic h_sem_wr, h_sem_rd, d_sem_wr, d_sem_rd, h_cfg_wr;
  assign h_sem_wr = h_en && h_we  && h_is_sem && h_act && h_own_sem;
  assign h_sem_rd = h_en && !h_we && h_is_sem && h_act;
  assign d_sem_wr = d_en && d_we  && d_is_sem && d_act && d_own_sem;
  assign d_sem_rd = d_en && !d_we && d_is_sem && d_act;
  assign h_cfg_wr = h_en && h_we  && h_is_cfg;

  always_comb begin
    sem_d  = sem_q;
    hflg_d = hflg_q;
    dflg_d = dflg_q;
    if (h_sem_rd) hflg_d[h_sidx] = 1'b0;
    if (d_sem_rd) dflg_d[d_sidx] = 1'b0;
    if (h_sem_wr && (h_wdata[0] != sem_q[h_sidx])) begin
      sem_d[h_sidx] = h_wdata[0];
      if (die_q[h_sidx]) dflg_d[h_sidx] = 1'b1;
    end
    if (d_sem_wr && (d_wdata[0] != sem_q[d_sidx])) begin
      sem_d[d_sidx] = d_wdata[0];
      if (hie_q[d_sidx]) hflg_d[d_sidx] = 1'b1;
    end
  end

  always_comb begin
    cfg_word                 = '0;
    cfg_word[NMB-1:0]        = dir_q;
    cfg_word[2*NMB-1:NMB]    = hie_q;
    cfg_word[3*NMB-1:2*NMB]  = die_q;
    cfg_word[30:29]          = mode_q;
    cfg_word[31]             = srst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      hie_q  <= '0;
      die_q  <= '0;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= h_cfg_wr && h_wdata[31] && !srst_q;
      if (h_cfg_wr) begin
        dir_q  <= h_wdata[NMB-1:0];
        hie_q  <= h_wdata[2*NMB-1:NMB];
        die_q  <= h_wdata[3*NMB-1:2*NMB];
        mode_q <= h_wdata[30:29];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_q  <= '0;
      hflg_q <= '0;
      dflg_q <= '0;
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (srst_q) begin
      sem_q  <= '0;
      hflg_q <= '0;
      dflg_q <= '0;
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      sem_q  <= sem_d;
      hflg_q <= hflg_d;
      dflg_q <= dflg_d;
      if (h_dat_ok && h_we) mem_q[h_word] <= h_wdata;
      if (d_dat_ok && d_we) mem_q[d_word] <= d_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
      h_viol  <= 1'b0;
      d_rdata <= '0;
      d_viol  <= 1'b0;
    end else begin
      h_viol  <= h_dat_blk;
      d_viol  <= d_dat_blk;
      h_rdata <= '0;
      d_rdata <= '0;
      if (h_en && !h_we) begin
        if (h_dat_ok)
          h_rdata <= mem_q[h_word];
        else if (h_is_sem && h_act)
          h_rdata <= DW'({dflg_q[h_sidx], hflg_q[h_sidx], sem_q[h_sidx]});
        else if (h_is_cfg)
          h_rdata <= cfg_word;
      end
      if (d_en && !d_we) begin
        if (d_dat_ok)
          d_rdata <= mem_q[d_word];
        else if (d_is_sem && d_act)
          d_rdata <= DW'({dflg_q[d_sidx], hflg_q[d_sidx], sem_q[d_sidx]});
      end
    end
  end

  assign h_irq = |hflg_q;
  assign d_irq = |dflg_q;

endmodule

// File: rtl/mbox_sema_chk.sv
module mbox_sema_chk #(
  parameter int NMB = 8,
  parameter int DW  = 32,
  parameter int AW  = 6,
  localparam int REG_W = $clog2(NMB) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_en,
  input logic          h_we,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_rdata,
  input logic          h_viol,
  input logic          h_irq,
  input logic          d_en,
  input logic          d_we,
  input logic [AW-1:0] d_addr,
  input logic [DW-1:0] d_rdata,
  input logic          d_viol,
  input logic          d_irq,
  input logic          srst,
  input logic [NMB-1:0] sem,
  input logic [NMB-1:0] hflg,
  input logic [NMB-1:0] dflg
);
  localparam logic [AW-1:0] CFG_ADDR = AW'((1 << (AW-1)) | NMB);

  logic h_sem_rd;
  assign h_sem_rd = h_en && !h_we && h_addr[AW-1] && (int'(h_addr[REG_W-1:0]) < NMB);

  AST_VIOL_ZERO_H: assert property (@(posedge clk) disable iff (!rst_n) h_viol |-> h_rdata == '0); // R3
  AST_VIOL_ZERO_D: assert property (@(posedge clk) disable iff (!rst_n) d_viol |-> d_rdata == '0); // R3
  AST_HIRQ_FROM_DSP: assert property (@(posedge clk) disable iff (!rst_n) $rose(h_irq) |-> $past(d_en && d_we)); // R5
  AST_DIRQ_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n) $rose(d_irq) |-> $past(h_en && h_we)); // R5
  AST_SEM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) h_sem_rd |=> h_rdata[DW-1:3] == '0); // R7
  AST_DSP_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (d_en && !d_we && d_addr == CFG_ADDR) |=> d_rdata == '0); // R8
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) srst |=> !srst); // R10
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) srst |=> (sem == '0 && hflg == '0 && dflg == '0)); // R10
endmodule

bind mbox_sema_ctrl mbox_sema_chk #(.NMB(NMB), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_rdata(h_rdata), .h_viol(h_viol), .h_irq(h_irq),
  .d_en(d_en), .d_we(d_we), .d_addr(d_addr), .d_rdata(d_rdata), .d_viol(d_viol), .d_irq(d_irq),
  .srst(srst_q), .sem(sem_q), .hflg(hflg_q), .dflg(dflg_q)
);

// File: tb/tb_mbox_sema_ctrl.sv
module tb_mbox_sema_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_en = 1'b0, h_we = 1'b0, d_en = 1'b0, d_we = 1'b0;
  logic [5:0]  h_addr = '0, d_addr = '0;
  logic [31:0] h_wdata = '0, d_wdata = '0;
  logic [31:0] h_rdata, d_rdata;
  logic        h_viol, d_viol, h_irq, d_irq;

  mbox_sema_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_viol(h_viol), .h_irq(h_irq),
    .d_en(d_en), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .d_viol(d_viol), .d_irq(d_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          cyc;
    logic [31:0] rd;
    logic        viol;
    string       tag;
  } exp_t;

  exp_t hq[$];
  exp_t dq[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;

  localparam logic [5:0] CFG = 6'h28;
  function automatic logic [5:0] sem_a(input int i); return 6'h20 | 6'(i); endfunction
  function automatic logic [5:0] wrd(input int w); return 6'(w & 31); endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (hq.size() > 0 && hq[0].cyc == cyc - 1) begin
      e = hq.pop_front();
      check({e.tag, " host rdata"}, h_rdata, e.rd);
      check({e.tag, " host viol"}, 32'(h_viol), 32'(e.viol));
    end
    if (dq.size() > 0 && dq[0].cyc == cyc - 1) begin
      e = dq.pop_front();
      check({e.tag, " dsp rdata"}, d_rdata, e.rd);
      check({e.tag, " dsp viol"}, 32'(d_viol), 32'(e.viol));
    end
  end

  task automatic host_op(input logic we, input logic [5:0] a, input logic [31:0] wd,
                         input logic [31:0] erd, input logic ev, input string tag);
    exp_t e;
    @(negedge clk);
    d_en = 1'b0; h_en = 1'b1; h_we = we; h_addr = a; h_wdata = wd;
    e.cyc = cyc; e.rd = erd; e.viol = ev; e.tag = tag;
    hq.push_back(e);
  endtask

  task automatic dsp_op(input logic we, input logic [5:0] a, input logic [31:0] wd,
                        input logic [31:0] erd, input logic ev, input string tag);
    exp_t e;
    @(negedge clk);
    h_en = 1'b0; d_en = 1'b1; d_we = we; d_addr = a; d_wdata = wd;
    e.cyc = cyc; e.rd = erd; e.viol = ev; e.tag = tag;
    dq.push_back(e);
  endtask

  task automatic chk_irq(input logic eh, input logic ed, input string tag);
    @(negedge clk);
    h_en = 1'b0; d_en = 1'b0;
    check({tag, " h_irq"}, 32'(h_irq), 32'(eh));
    check({tag, " d_irq"}, 32'(d_irq), 32'(ed));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  localparam logic [31:0] CFG0 = 32'h0005FF0F;
  localparam logic [31:0] CFGM1 = 32'h2005FF0F;
  localparam logic [31:0] CFGM3 = 32'h6005FF0F;
  localparam logic [31:0] CFGSR = 32'h8005FF0F;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset h_rdata", h_rdata, 32'h0);
    check("R11 reset irqs", {30'b0, h_irq, d_irq}, 32'h0);
    host_op(0, CFG, 0, 32'h0, 0, "R11 cfg after reset");
    host_op(0, sem_a(0), 0, 32'h0, 0, "R11 sem after reset");

    host_op(1, CFG, CFG0, 32'h0, 0, "R8 cfg write");
    host_op(0, CFG, 0, CFG0, 0, "R8 cfg readback");
    dsp_op(0, CFG, 0, 32'h0, 0, "R8 dsp cfg read is zero");
    dsp_op(1, CFG, 32'hFFFF_FFFF, 32'h0, 0, "R8 dsp cfg write");
    host_op(0, CFG, 0, CFG0, 0, "R8 dsp cfg write ignored");

    host_op(1, wrd(0), 32'hA5A5_0001, 32'h0, 0, "R1 host data write");
    host_op(0, wrd(0), 0, 32'hA5A5_0001, 0, "R2 sender owns at sem0");
    dsp_op(0, wrd(0), 0, 32'h0, 1, "R3 blocked read");
    dsp_op(1, wrd(0), 32'h1234, 32'h0, 1, "R3 blocked write");
    host_op(0, wrd(0), 0, 32'hA5A5_0001, 0, "R3 blocked write dropped");

    dsp_op(1, sem_a(0), 1, 32'h0, 0, "R4 non-owner sem write");
    dsp_op(0, sem_a(0), 0, 32'h0, 0, "R4 non-owner write ignored");
    host_op(1, sem_a(0), 7, 32'h0, 0, "R4 owner sets sem");
    chk_irq(0, 1, "R5 dsp interrupt raised");
    host_op(0, sem_a(0), 0, 32'h5, 0, "R7 host view of sem word");
    dsp_op(0, sem_a(0), 0, 32'h5, 0, "R7 dsp view of sem word");
    chk_irq(0, 0, "R6 dsp read clears flag");
    dsp_op(0, sem_a(0), 0, 32'h1, 0, "R6 flag bit cleared");

    dsp_op(0, wrd(0), 0, 32'hA5A5_0001, 0, "R2 recipient owns at sem1");
    host_op(0, wrd(0), 0, 32'h0, 1, "R3 sender blocked at sem1");
    dsp_op(1, sem_a(0), 0, 32'h0, 0, "R4 recipient releases");
    chk_irq(1, 0, "R5 host interrupt raised");
    host_op(0, sem_a(0), 0, 32'h2, 0, "R7 host flag in bit1");
    chk_irq(0, 0, "R6 host read clears flag");

    host_op(1, sem_a(1), 1, 32'h0, 0, "R5 set with dsp enable off");
    chk_irq(0, 0, "R5 gated no interrupt");
    dsp_op(0, sem_a(1), 0, 32'h1, 0, "R5 sem set without flag");

    host_op(1, wrd(16), 32'hDEAD, 32'h0, 1, "R2 dsp-sender mailbox blocks host");
    dsp_op(1, wrd(16), 32'h44, 32'h0, 0, "R2 dsp sender writes");
    dsp_op(0, wrd(16), 0, 32'h44, 0, "R2 dsp sender reads");

    host_op(1, CFG, CFGM1, 32'h0, 0, "R9 mode 1");
    host_op(0, wrd(8), 0, 32'h0, 1, "R9 mode1 word8 in mailbox1");
    dsp_op(0, wrd(8), 0, 32'h0, 0, "R9 mode1 dsp owns mailbox1");

    host_op(1, CFG, CFGM3, 32'h0, 0, "R9 mode 3");
    host_op(0, wrd(16), 0, 32'h44, 0, "R9 mode3 single mailbox");
    dsp_op(1, sem_a(4), 1, 32'h0, 0, "R9 inactive sem write");
    dsp_op(0, sem_a(4), 0, 32'h0, 0, "R9 inactive sem reads zero");
    host_op(1, CFG, CFG0, 32'h0, 0, "R9 back to mode 0");
    dsp_op(0, sem_a(4), 0, 32'h0, 0, "R9 inactive write had no effect");
    chk_irq(0, 0, "R9 no flag from inactive write");

    dsp_op(1, sem_a(1), 0, 32'h0, 0, "R4 recipient releases mailbox1");
    chk_irq(1, 0, "R5 host flag pending");
    host_op(1, CFG, CFGSR, 32'h0, 0, "R10 soft reset write");
    host_op(0, CFG, 0, CFGSR, 0, "R10 reset bit visible");
    host_op(0, CFG, 0, CFG0, 0, "R10 reset bit self-clears");
    chk_irq(0, 0, "R10 flags cleared");
    host_op(0, wrd(0), 0, 32'h0, 0, "R10 host data cleared");
    dsp_op(0, sem_a(1), 0, 32'h0, 0, "R10 sem cleared");
    dsp_op(0, wrd(16), 0, 32'h0, 0, "R10 dsp data cleared");

    repeat (3) @(negedge clk);
    h_en = 1'b0; d_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", 32'(hq.size() + dq.size()), 32'h0);
    summary();
  end
endmodule